// File: doc/BRIEF.md
# Multi-Bank Signal Event Router

This block watches a wide set of asynchronous signals, organised as banks of equal width, and turns each one into an event. Every signal has its own polarity and its own choice of level or edge sensing, so a line can fire while it is high, while it is low, on a rising transition or on a falling transition. The signals can come from anywhere on the chip: general-purpose pins, peripheral inputs, or outputs that peripherals drive themselves. Each signal first passes through a two-flop synchronizer.

The result of the polarity and sensing stage is the raw status. Edge events are held in a per-signal latch until software clears them, and level events follow the synchronized input. A per-signal mask turns the raw status into pending status. The pending vector is sent out as a bus of module clock enables, and its OR is the interrupt line. Only the enable signals are produced here. No clock is gated inside the block.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The block carries no data stream, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `evtr_router`

## Requirements
- R1: Reset (synchronous, active high `rst`) clears all polarity, sensitivity and mask bits and all edge latches, so pending, `clk_en_o` and `irq_o` are all 0 after reset.
- R2: Each input reaches the event logic through two flops: a change on `sig_in` that is held steady is seen by level sensing after the second rising clock edge and not after the first.
- R3: With sensitivity bit 0 (level), raw status equals the synchronized input when the polarity bit is 1 and its inverse when the polarity bit is 0, and it follows the input in both directions.
- R4: With sensitivity bit 1 and polarity bit 1, a 0-to-1 transition sets the raw bit one clock after it reaches level sensing. The bit stays set after the input returns to 0.
- R5: With sensitivity bit 1 and polarity bit 0, a 1-to-0 transition sets and holds the raw bit in the same way.
- R6: Writing to the clear register clears the latched edge bits whose data bit is 1 and leaves the bits written 0 unchanged.
- R7: Pending status is raw status AND mask. It is readable per bank, and a masked-off bit never appears as pending.
- R8: `irq_o` is 1 exactly when at least one pending bit is set in any bank.
- R9: `clk_en_o` equals the pending vector, with bank b on bits [32*b+31 : 32*b].
- R10: Register address is {bank[1:0], func[2:0]}, with func 0 polarity, 1 sensitivity, 2 mask, 3 raw, 4 pending and 5 clear. Polarity, sensitivity and mask read back what was written. Func 5, 6 and 7 read as 0.
- R11: Writes to the raw and pending addresses are ignored.
- R12: While a signal's sensitivity bit is 0, its edge latch is held at 0. A latched edge is therefore discarded when the signal is switched to level mode, and it does not come back when the signal is switched back to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 128 | Monitored signals, asynchronous, bank b on bits [32*b+31:32*b] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {bank, func} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address {bank, func} |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | OR of all pending bits |
| clk_en_o | output | 128 | Per-signal clock enables, equal to pending |

## Verification
A table of vectors drives one bank with a steady "before" pattern and then a "after" pattern, under pure level-high, pure level-low, all-rising, all-falling, a byte-wise mix of all four modes, an all-masked case and a single-bit case. The all-masked case tells raw apart from pending. The mixed case tells the four modes apart from one another inside one word. Directed tests then check the two-cycle synchronizer delay, that edge latches hold after the input returns, partial clears, and that a latch is discarded on a switch to level mode. They also check the register map, including writes to read-only addresses.

// File: rtl/evtr_pkg.sv
package evtr_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    F_POL  = 3'd0,
    F_SENS = 3'd1,
    F_MASK = 3'd2,
    F_RAW  = 3'd3,
    F_PEND = 3'd4,
    F_CLR  = 3'd5
  } func_e;
endpackage

// File: rtl/evtr_sync.sv
module evtr_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/evtr_bank.sv
module evtr_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s,
  input  logic         we_pol,
  input  logic         we_sens,
  input  logic         we_mask,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] sens_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] level_ev,
  output logic [W-1:0] edge_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] hit;

  always_comb begin
    rise     = s & ~prev_q;
    fall     = ~s & prev_q;
    hit      = (pol_q & rise) | (~pol_q & fall);
    level_ev = (pol_q & s) | (~pol_q & ~s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      sens_q <= '0;
      mask_q <= '0;
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= s;
      if (we_pol)  pol_q  <= wdata;
      if (we_sens) sens_q <= wdata;
      if (we_mask) mask_q <= wdata;
      edge_q <= sens_q & ((edge_q & ~clr_bits) | hit);
    end
  end
endmodule

// File: rtl/evtr_router.sv
module evtr_router
  import evtr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = BANK_IDX_W + FUNC_W,
  localparam int NUM_SIG    = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SIG-1:0]   sig_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BANK_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BANK_W-1:0]    rd_data,
  output logic                 irq_o,
  output logic [NUM_SIG-1:0]   clk_en_o
);
  logic [NUM_SIG-1:0] sync_v;
  logic [NUM_SIG-1:0] pol_v;
  logic [NUM_SIG-1:0] sens_v;
  logic [NUM_SIG-1:0] mask_v;
  logic [NUM_SIG-1:0] level_v;
  logic [NUM_SIG-1:0] edge_v;
  logic [NUM_SIG-1:0] clr_v;
  logic [NUM_SIG-1:0] raw_v;
  logic [NUM_SIG-1:0] pend_v;

  logic [BANK_IDX_W-1:0] wr_bank;
  logic [FUNC_W-1:0]     wr_func;
  logic [BANK_IDX_W-1:0] rd_bank;
  logic [FUNC_W-1:0]     rd_func;

  assign wr_bank = wr_addr[ADDR_W-1:FUNC_W];
  assign wr_func = wr_addr[FUNC_W-1:0];
  assign rd_bank = rd_addr[ADDR_W-1:FUNC_W];
  assign rd_func = rd_addr[FUNC_W-1:0];

  evtr_sync #(.W(NUM_SIG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sig_in),
    .q   (sync_v)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_en && (wr_bank == BANK_IDX_W'(b));
    assign clr_v[b*BANK_W +: BANK_W] =
      (sel && wr_func == F_CLR) ? wr_data : '0;

    evtr_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .s        (sync_v[b*BANK_W +: BANK_W]),
      .we_pol   (sel && wr_func == F_POL),
      .we_sens  (sel && wr_func == F_SENS),
      .we_mask  (sel && wr_func == F_MASK),
      .clr_bits (clr_v[b*BANK_W +: BANK_W]),
      .wdata    (wr_data),
      .pol_q    (pol_v[b*BANK_W +: BANK_W]),
      .sens_q   (sens_v[b*BANK_W +: BANK_W]),
      .mask_q   (mask_v[b*BANK_W +: BANK_W]),
      .level_ev (level_v[b*BANK_W +: BANK_W]),
      .edge_q   (edge_v[b*BANK_W +: BANK_W])
    );
  end

  assign raw_v    = (sens_v & edge_v) | (~sens_v & level_v);
  assign pend_v   = raw_v & mask_v;
  assign clk_en_o = pend_v;
  assign irq_o    = |pend_v;

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_bank == BANK_IDX_W'(b)) begin
        case (rd_func)
          F_POL:   rd_data = pol_v[b*BANK_W +: BANK_W];
          F_SENS:  rd_data = sens_v[b*BANK_W +: BANK_W];
          F_MASK:  rd_data = mask_v[b*BANK_W +: BANK_W];
          F_RAW:   rd_data = raw_v[b*BANK_W +: BANK_W];
          F_PEND:  rd_data = pend_v[b*BANK_W +: BANK_W];
          default: rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/evtr_router_chk.sv
module evtr_router_chk #(
  parameter int NUM_SIG = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_o,
  input logic [NUM_SIG-1:0] clk_en_o,
  input logic [NUM_SIG-1:0] mask_v,
  input logic [NUM_SIG-1:0] sens_v,
  input logic [NUM_SIG-1:0] edge_v,
  input logic [NUM_SIG-1:0] clr_v
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (mask_v == '0 && sens_v == '0 && edge_v == '0)); // R1

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_v & $past(edge_v & ~clr_v & sens_v)) ==
              $past(edge_v & ~clr_v & sens_v))); // R4

  AST_LEVEL_DROPS_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_v & $past(~sens_v)) == '0)); // R12

  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (rst)
    irq_o == (clk_en_o != '0)); // R8
endmodule

bind evtr_router evtr_router_chk #(.NUM_SIG(NUM_SIG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .clk_en_o (clk_en_o),
  .mask_v   (mask_v),
  .sens_v   (sens_v),
  .edge_v   (edge_v),
  .clr_v    (clr_v)
);

// File: tb/test_evtr_router.sv
`timescale 1ns/1ps
module test_evtr_router;
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int NS = NB * BW;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] sig_in = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [BW-1:0] rd_data;
  logic          irq_o;
  logic [NS-1:0] clk_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  evtr_router i_evtr_router (
    .clk(clk), .rst(rst), .sig_in(sig_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .clk_en_o(clk_en_o)
  );

  // one vector: pol, sens, mask, input before, input after, raw, pending
  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] sens;
    logic [31:0] mask;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic [31:0] raw;
    logic [31:0] pend;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'hA5A50F0F, 32'hA5A50F0F, 32'hA5A50F0F},
    '{32'h0,        32'h0,        32'hFFFF0000, 32'h0,        32'hA5A50F0F, 32'h5A5AF0F0, 32'h5A5A0000},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'h00FF0000, 32'h00FF0000},
    '{32'h0,        32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0000FFFF, 32'h00FF00FF, 32'h0000FF00, 32'h00000F00},
    '{32'h0000FFFF, 32'h00FF00FF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h33333333, 32'hCC0C3330, 32'hCC0C3330},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h0,        32'h80000001, 32'h80000001, 32'h80000000}
  };

  function automatic logic [AW-1:0] ad(input int bank, input int func);
    return AW'(bank * 8 + func);
  endfunction

  task automatic chk(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [BW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic drive(input int bank, input logic [BW-1:0] v);
    sig_in[bank*BW +: BW] = v;
  endtask

  logic [BW-1:0] r;

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    rd(ad(0, 0), r); chk("R1 pol after reset", r, 32'h0);
    rd(ad(0, 1), r); chk("R1 sens after reset", r, 32'h0);
    rd(ad(0, 2), r); chk("R1 mask after reset", r, 32'h0);
    rd(ad(0, 4), r); chk("R1 pending after reset", r, 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 clk_en after reset", 32'(clk_en_o != '0), 32'h0);
    // R3 default level-low with inputs low reads all ones
    rd(ad(0, 3), r); chk("R3 default level-low raw", r, 32'hFFFFFFFF);

    // table walk on bank 1
    for (int k = 0; k < NV; k++) begin
      drive(1, VECS[k].in_a);
      tick(4);
      wr(ad(1, 0), VECS[k].pol);
      wr(ad(1, 1), VECS[k].sens);
      wr(ad(1, 2), VECS[k].mask);
      wr(ad(1, 5), 32'hFFFFFFFF);
      tick(1);
      drive(1, VECS[k].in_b);
      tick(4);
      rd(ad(1, 3), r); chk($sformatf("R3/R4/R5 raw vec %0d", k), r, VECS[k].raw);
      rd(ad(1, 4), r); chk($sformatf("R7 pending vec %0d", k), r, VECS[k].pend);
      chk($sformatf("R9 clk_en vec %0d", k), clk_en_o[BW +: BW], VECS[k].pend);
      chk($sformatf("R8 irq vec %0d", k), {31'h0, irq_o}, {31'h0, VECS[k].pend != 0});
    end
    wr(ad(1, 2), 32'h0);

    // R2 synchronizer depth on bank 2, level-high
    wr(ad(2, 0), 32'hFFFFFFFF);
    tick(2);
    drive(2, 32'h1);
    @(negedge clk);
    rd(ad(2, 3), r); chk("R2 not seen after one edge", r, 32'h0);
    @(negedge clk);
    rd(ad(2, 3), r); chk("R2 seen after two edges", r, 32'h1);
    drive(2, 32'h0);
    tick(3);
    rd(ad(2, 3), r); chk("R3 level follows input back low", r, 32'h0);

    // R4 hold, R6 partial clear, R12 discard, bank 2 edge rising
    wr(ad(2, 1), 32'hFFFFFFFF);
    wr(ad(2, 5), 32'hFFFFFFFF);
    drive(2, 32'h30);
    tick(4);
    drive(2, 32'h0);
    tick(4);
    rd(ad(2, 3), r); chk("R4 edge held after input falls", r, 32'h30);
    wr(ad(2, 5), 32'h20);
    tick(1);
    rd(ad(2, 3), r); chk("R6 clear only written-1 bits", r, 32'h10);
    // R11 writes to raw and pending ignored
    wr(ad(2, 3), 32'h0);
    wr(ad(2, 4), 32'hFFFFFFFF);
    rd(ad(2, 3), r); chk("R11 raw write ignored", r, 32'h10);
    rd(ad(2, 2), r); chk("R11 mask untouched by pending write", r, 32'h0);
    // R12 switch to level drops latch
    wr(ad(2, 1), 32'h0);
    tick(1);
    rd(ad(2, 3), r); chk("R12 level view after switch", r, 32'h0);
    wr(ad(2, 1), 32'hFFFFFFFF);
    tick(1);
    rd(ad(2, 3), r); chk("R12 latch not restored", r, 32'h0);

    // R10 register map
    wr(ad(3, 0), 32'h12345678);
    wr(ad(3, 1), 32'h9ABCDEF0);
    wr(ad(3, 2), 32'h0F1E2D3C);
    rd(ad(3, 0), r); chk("R10 pol readback", r, 32'h12345678);
    rd(ad(3, 1), r); chk("R10 sens readback", r, 32'h9ABCDEF0);
    rd(ad(3, 2), r); chk("R10 mask readback", r, 32'h0F1E2D3C);
    rd(ad(3, 5), r); chk("R10 clear reads zero", r, 32'h0);
    rd(ad(3, 6), r); chk("R10 func6 reads zero", r, 32'h0);
    rd(ad(3, 7), r); chk("R10 func7 reads zero", r, 32'h0);
    rd(ad(0, 0), r); chk("R10 other bank untouched", r, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule